// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of an 8-bit successive-approximation converter. It makes conversion-clock periods in one of two ways. The first is to divide the system clock by a ratio picked with a 3-bit select code. The second is to count pulses from an external RC-oscillator tick that arrives already synchronized to the system clock. Software starts a conversion by setting a start bit.

From the clock edge that accepts the start, the sample capacitor is disconnected and the block walks through nine conversion periods. The first period only isolates the capacitor. Each of the next eight periods tests one result bit, starting with the top bit. The block drives a trial code to an external DAC and samples a one-bit comparator that reports whether the held input is at or above that code.

One clock after the last period ends, the block completes the conversion. It stores the code in the result register, drops the start bit, raises a sticky completion flag and reconnects the capacitor. Software can abort a running conversion by clearing the start bit. During sleep, a conversion progresses only when the RC-oscillator source is selected.

Top module: `sar_sequencer`

## Requirements
- R1: The select code sets the period length in system clocks: 000 gives 2, 100 gives 4, 001 gives 8, 101 gives 16, 010 gives 32 and 110 gives 64. The divider restarts at each accepted start. For a divide ratio N and a start sampled at clock edge E, the completion outputs appear after edge E+9N+1.
- R2: Any select code whose two low bits are both 1 takes each period boundary from a pulse on `rcTick` instead. With no pulses, the conversion does not advance.
- R3: The conversion tests bits 7 down to 0, one per period. Each trial sets the bit under test to 1 on `dacCode`. At the next period boundary that bit is kept if `cmpAbove` is 1 and cleared if it is 0. For an ideal comparator, the result equals the held input code.
- R4: `holdConnect` goes low on the clock after a start is accepted. It stays low until completion or abort.
- R5: A conversion spans nine periods. During the first period `dacCode` is 0. At the end of the first period `dacCode` becomes 8'h80, which is the trial for bit 7.
- R6: On the clock after the ninth period ends, four things happen together: `result` is loaded, `busy` goes low, `doneFlag` goes high and `holdConnect` goes high.
- R7: While `sleepMode` is high with a divided source selected, a conversion does not advance. With an RC source selected, it completes during sleep.
- R8: A `startSet` pulse while `busy` is high has no effect on the running conversion or its timing.
- R9: A `startClr` pulse while `busy` is high aborts the conversion: `busy` drops and `holdConnect` rises on the next clock, `result` keeps its old value and `doneFlag` stays low.
- R10: `doneFlag` stays high until a `flagClr` pulse clears it.
- R11: After reset, `result` is 0, `doneFlag` and `busy` are low and `holdConnect` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSel | input | 3 | Conversion clock select code |
| rcTick | input | 1 | One-clock pulse per RC-oscillator period |
| sleepMode | input | 1 | Chip in sleep; stops the divided clock |
| startSet | input | 1 | Software write setting the start bit |
| startClr | input | 1 | Software write clearing the start bit |
| flagClr | input | 1 | Software write clearing the completion flag |
| cmpAbove | input | 1 | Comparator: held input at or above DAC code |
| busy | output | 1 | Start bit readback, high during a conversion |
| doneFlag | output | 1 | Sticky completion flag |
| holdConnect | output | 1 | High when the sample capacitor tracks the input |
| dacCode | output | 8 | Trial code to the DAC |
| result | output | 8 | Result register |

## Verification
The assertions check a set of properties on every cycle. The finish state lasts exactly one clock and completion raises the flag with `busy` low. The result register changes only on a load strobe. An abort never raises the flag. The step counter stays in range. The divider stays frozen during sleep with a divided source. The first trial lands on the top bit. The bench scenarios are needed for properties that cover a whole conversion: the exact completion cycle for every divide ratio, the converted values against an ideal comparator model, a start written mid-conversion leaving the timing untouched, and the RC and sleep behaviour.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAR_BITS = 8;
  localparam int STEP_W   = $clog2(SAR_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CONV   = 2'd1,
    ST_FINISH = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              clear;    // conversion accepted: zero the trial register
    logic              advance;  // a period boundary inside the conversion
    logic [STEP_W-1:0] step;     // index of the period that just ended
    logic              load;     // completion: copy trial register to result
  } sarStrobe_t;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       restart,
  input  logic       run,
  input  logic       sleepMode,
  input  logic       rcTick,
  input  logic [2:0] clkSel,
  output logic       tadTick
);
  localparam int RAT_W = DIV_W + 1;

  logic [DIV_W-1:0] divCnt;
  logic [RAT_W-1:0] ratio;
  logic [2:0]       shAmt;
  logic             useRc, divEnd, divRun;

  always_comb begin
    useRc   = &clkSel[1:0];
    shAmt   = {clkSel[1:0], 1'b0} + {2'b00, clkSel[2]};
    ratio   = RAT_W'(2) << shAmt;
    divEnd  = ({1'b0, divCnt} >= (ratio - RAT_W'(1)));
    divRun  = run && !useRc && !sleepMode;
    tadTick = run && (useRc ? rcTick : (divRun && divEnd));
  end

  always_ff @(posedge clk) begin
    if (!rstN)        divCnt <= '0;
    else if (restart) divCnt <= '0;
    else if (divRun)  divCnt <= divEnd ? '0 : divCnt + DIV_W'(1);
  end

  // R7: sleep with a divided source freezes the period counter
  p_sleep_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode && !useRc && !restart) |=> $stable(divCnt));
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int RES_W = SAR_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strb,
  input  logic             cmpAbove,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] result
);
  logic [RES_W-1:0] sarReg, nextSar, resultReg;

  generate
    for (genvar b = 0; b < RES_W; b++) begin : g_bit
      // bit b is trialled when period RES_W-1-b ends, resolved when RES_W-b ends
      always_comb begin
        nextSar[b] = sarReg[b];
        if (strb.clear) nextSar[b] = 1'b0;
        else if (strb.advance) begin
          if (strb.step == STEP_W'(RES_W - b))     nextSar[b] = cmpAbove;
          if (strb.step == STEP_W'(RES_W - 1 - b)) nextSar[b] = 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarReg    <= '0;
      resultReg <= '0;
    end else begin
      sarReg <= nextSar;
      if (strb.load) resultReg <= sarReg;
    end
  end

  assign dacCode = sarReg;
  assign result  = resultReg;

  // R9: result only moves on a completion load
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(resultReg));
  // R3: the first trial sets the top bit
  p_first_trial_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.step == '0) |=> dacCode[RES_W-1]);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W = SAR_BITS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSet,
  input  logic       startClr,
  input  logic       flagClr,
  input  logic       tadTick,
  output sarStrobe_t strb,
  output logic       runDiv,
  output logic       restartDiv,
  output logic       busy,
  output logic       doneFlag,
  output logic       holdConnect
);
  seqState_t         state;
  logic [STEP_W-1:0] step;
  logic              flagReg, startAcc, abort, lastStep;

  always_comb begin
    startAcc     = startSet && !startClr && (state == ST_IDLE);
    abort        = startClr && (state != ST_IDLE);
    lastStep     = (step == STEP_W'(RES_W));
    strb.clear   = startAcc;
    strb.advance = (state == ST_CONV) && tadTick && !abort;
    strb.step    = step;
    strb.load    = (state == ST_FINISH) && !abort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      step    <= '0;
      flagReg <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (startAcc) begin
          state <= ST_CONV;
          step  <= '0;
        end
        ST_CONV: begin
          if (abort) state <= ST_IDLE;
          else if (tadTick) begin
            if (lastStep) state <= ST_FINISH;
            else          step  <= step + STEP_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (strb.load)    flagReg <= 1'b1;
      else if (flagClr) flagReg <= 1'b0;
    end
  end

  assign runDiv      = (state == ST_CONV);
  assign restartDiv  = startAcc;
  assign busy        = (state != ST_IDLE);
  assign holdConnect = (state == ST_IDLE);
  assign doneFlag    = flagReg;

  // R6: completion step lasts one clock and raises the flag with busy low
  p_finish_exit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH) |=> (state == ST_IDLE));
  p_flag_on_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (doneFlag && !busy && holdConnect));
  // R9: an abort never raises the flag
  p_abort_noflag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (abort && !doneFlag) |=> !doneFlag);
  // R5: nine periods indexed 0..RES_W
  p_step_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    step <= STEP_W'(RES_W));
  // R8: a repeated start mid-conversion keeps it running
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && startSet && !startClr && !tadTick) |=> busy);
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int RES_W = SAR_BITS,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       clkSel,
  input  logic             rcTick,
  input  logic             sleepMode,
  input  logic             startSet,
  input  logic             startClr,
  input  logic             flagClr,
  input  logic             cmpAbove,
  output logic             busy,
  output logic             doneFlag,
  output logic             holdConnect,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] result
);
  sarStrobe_t strb;
  logic       tadTick, runDiv, restartDiv;

  sar_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rstN(rstN), .restart(restartDiv), .run(runDiv),
    .sleepMode(sleepMode), .rcTick(rcTick), .clkSel(clkSel), .tadTick(tadTick)
  );

  sar_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startSet(startSet), .startClr(startClr),
    .flagClr(flagClr), .tadTick(tadTick), .strb(strb), .runDiv(runDiv),
    .restartDiv(restartDiv), .busy(busy), .doneFlag(doneFlag),
    .holdConnect(holdConnect)
  );

  sar_datapath #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpAbove(cmpAbove),
    .dacCode(dacCode), .result(result)
  );
endmodule

// File: tb/sar_sequencer_tb.sv
module sar_sequencer_tb;
  logic       clk = 1'b0, rstN = 1'b0;
  logic [2:0] clkSel = 3'b000;
  logic       rcTick = 1'b0, sleepMode = 1'b0, startSet = 1'b0;
  logic       startClr = 1'b0, flagClr = 1'b0, cmpAbove;
  logic       busy, doneFlag, holdConnect;
  logic [7:0] dacCode, result, vinModel = 8'h00;
  logic       rcEn = 1'b0;
  int         rcDiv = 0;

  typedef struct { logic [7:0] res; int doneAt; } expItem_t;
  expItem_t expQ[$];
  expItem_t it;

  int checks = 0, errors = 0, cycleCnt = 0, doneCnt = 0, c0 = 0;
  logic prevFlag = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  sar_sequencer u_dut (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .rcTick(rcTick),
    .sleepMode(sleepMode), .startSet(startSet), .startClr(startClr),
    .flagClr(flagClr), .cmpAbove(cmpAbove), .busy(busy), .doneFlag(doneFlag),
    .holdConnect(holdConnect), .dacCode(dacCode), .result(result)
  );

  // ideal comparator: held input at or above the DAC code
  assign cmpAbove = (vinModel >= dacCode);

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  always @(negedge clk) begin
    if (rcEn) begin
      rcDiv  = rcDiv + 1;
      rcTick = (rcDiv % 5 == 0);
    end else rcTick = 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ratioOf(input logic [2:0] s);
    case (s)
      3'b000: return 2;
      3'b100: return 4;
      3'b001: return 8;
      3'b101: return 16;
      3'b010: return 32;
      3'b110: return 64;
      default: return -1;
    endcase
  endfunction

  // monitor: pops an expected item on every rise of the completion flag
  always @(negedge clk) begin
    if (rstN && doneFlag && !prevFlag) begin
      if (expQ.size() == 0) check(0, "R9", "unexpected completion", 1, 0);
      else begin
        it = expQ.pop_front();
        check(result == it.res, "R3", "converted code", result, it.res);
        check(!busy && holdConnect, "R6", "busy/hold at completion",
              {busy, holdConnect}, 2'b01);
        if (it.doneAt >= 0)
          check(cycleCnt == it.doneAt, "R1", "completion cycle", cycleCnt, it.doneAt);
      end
      doneCnt++;
    end
    prevFlag = doneFlag;
  end

  // driver: issues a start and pushes the expected outcome
  task automatic startConv(input logic [2:0] s, input logic [7:0] vin, input bit push);
    int r;
    @(negedge clk); clkSel = s; vinModel = vin; startSet = 1'b1;
    @(negedge clk); startSet = 1'b0; c0 = cycleCnt;
    r = ratioOf(s);
    if (push) expQ.push_back('{res: vin, doneAt: (r < 0) ? -1 : c0 + 9 * r + 1});
  endtask

  task automatic waitDone(input int tgt);
    while (doneCnt < tgt) @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    check(doneFlag == 1'b0, "R10", "flag after clear", doneFlag, 0);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [2:0] selList [5] = '{3'b100, 3'b001, 3'b101, 3'b010, 3'b110};
    logic [7:0] vinList [5] = '{8'h00, 8'hFF, 8'h5A, 8'h80, 8'h7F};
    repeat (5) @(negedge clk);
    check(result == 8'h00, "R11", "reset result", result, 0);
    check(!doneFlag && !busy, "R11", "reset flag/busy", {doneFlag, busy}, 0);
    check(holdConnect == 1'b1, "R11", "reset hold", holdConnect, 1);
    rstN = 1'b1;

    // divide-by-2 with period-level probes
    startConv(3'b000, 8'hA5, 1'b1);
    check(holdConnect == 1'b0 && busy, "R4", "hold after start", holdConnect, 0);
    check(dacCode == 8'h00, "R5", "dac in first period", dacCode, 0);
    repeat (2) @(negedge clk);
    check(dacCode == 8'h80, "R5", "first trial code", dacCode, 8'h80);
    check(holdConnect == 1'b0, "R4", "hold during bits", holdConnect, 0);
    waitDone(1);
    clearFlag();

    // every other divided ratio
    for (int i = 0; i < 5; i++) begin
      startConv(selList[i], vinList[i], 1'b1);
      waitDone(2 + i);
      if (i == 0) begin
        repeat (20) @(negedge clk);
        check(doneFlag == 1'b1, "R10", "flag sticky", doneFlag, 1);
      end
      clearFlag();
    end

    // R8: start rewritten mid-conversion
    startConv(3'b001, 8'h3C, 1'b1);
    repeat (10) @(negedge clk);
    startSet = 1'b1; @(negedge clk); startSet = 1'b0;
    check(busy == 1'b1, "R8", "busy after repeated start", busy, 1);
    waitDone(7);
    clearFlag();

    // R9: abort
    startConv(3'b000, 8'hC3, 1'b0);
    repeat (7) @(negedge clk);
    startClr = 1'b1; @(negedge clk); startClr = 1'b0;
    check(!busy && holdConnect, "R9", "abort busy/hold", {busy, holdConnect}, 2'b01);
    repeat (30) @(negedge clk);
    check(doneFlag == 1'b0, "R9", "abort flag", doneFlag, 0);
    check(result == 8'h3C, "R9", "abort keeps result", result, 8'h3C);

    // R7: sleep with divided source stalls
    sleepMode = 1'b1;
    startConv(3'b010, 8'h11, 1'b1);
    expQ[expQ.size()-1].doneAt = -1;
    repeat (300) @(negedge clk);
    check(busy == 1'b1 && dacCode == 8'h00, "R7", "no progress in sleep",
          {busy, dacCode}, {1'b1, 8'h00});
    sleepMode = 1'b0;
    waitDone(8);
    clearFlag();

    // R2: RC source
    startConv(3'b011, 8'h96, 1'b1);
    repeat (100) @(negedge clk);
    check(busy == 1'b1 && dacCode == 8'h00, "R2", "no RC ticks, no progress",
          {busy, dacCode}, {1'b1, 8'h00});
    rcEn = 1'b1;
    waitDone(9);
    clearFlag();

    // R7: RC source completes in sleep
    sleepMode = 1'b1;
    startConv(3'b111, 8'h69, 1'b1);
    waitDone(10);
    sleepMode = 1'b0; rcEn = 1'b0;
    clearFlag();

    check(expQ.size() == 0, "R6", "all conversions completed", expQ.size(), 0);
    finish();
  end
endmodule